// File: doc/BRIEF.md
# Receive Character Queue with Per-Entry Error Flags

This block sits between a serial character receiver and the host. Each assembled character is stored with its own parity, framing and overrun flags in a small first-in first-out queue, three entries deep by default. The flags leave the queue together with their character. The host can therefore check the error status of the oldest character before reading it.

An occupancy state machine with three states drives the queue. EMPTY moves to PARTIAL on a write. PARTIAL moves to FULL when a write fills the last entry, and back to EMPTY when a read takes the last character. FULL moves to PARTIAL on a read without a write. A write into FULL without a read is an overrun. The state stays FULL, the newest stored character is replaced, and its entry is marked as overrun. When a read and a write arrive together in a non-empty state, the state is kept.

Parity and overrun status are sticky: they stay set until the host issues an error reset. A special-condition interrupt request follows the parity status when it is armed. Framing status is never held and always describes the oldest entry.

Top module: `rxq_top`

## Requirements
- R1: After reset, char_avail, stat_par, stat_frm, stat_ovr and sc_irq are 0 and rd_data is 0.
- R2: Characters leave in the order they were written, up to DEPTH (3) held at once. char_avail is 1 exactly when at least one character is held.
- R3: A read with at least one character held loads the oldest character into rd_data on that clock edge and removes it from the queue.
- R4: A read while the queue is empty leaves rd_data unchanged and removes nothing.
- R5: stat_frm is 1 only while the oldest held character was written with its framing flag. It is not held once that character is read.
- R6: stat_par is 1 while the oldest held character carries a parity flag. It stays 1 after that character is read, until an error reset.
- R7: A write while the queue is full and no read is given replaces the newest held character and marks that entry as overrun. It also sets stat_ovr, which stays 1 until an error reset. Older entries are kept.
- R8: An error reset clears the held parity and overrun status and the interrupt request, and removes no character. A clear and a new set in the same cycle leave the status clear.
- R9: sc_irq is 1 exactly when par_irq_en is 1 and stat_par is 1.
- R10: A read and a write in the same cycle are both taken when the queue is not empty, even when it is full, and no overrun results. When the queue is empty only the write is taken and rd_data is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Receiver delivers a character this cycle |
| wr_data | input | DW | Received character |
| wr_par_err | input | 1 | Parity error flag of the character |
| wr_frm_err | input | 1 | Framing error flag of the character |
| rd_en | input | 1 | Host read strobe |
| err_rst | input | 1 | Error reset command |
| par_irq_en | input | 1 | Arms the special-condition interrupt for parity errors |
| rd_data | output | DW | Last character read |
| char_avail | output | 1 | At least one character held |
| stat_par | output | 1 | Parity status (oldest entry or held) |
| stat_frm | output | 1 | Framing status of the oldest entry |
| stat_ovr | output | 1 | Overrun status (oldest entry or held) |
| sc_irq | output | 1 | Special-condition interrupt request |

## Verification
A wrong occupancy state shows at the ports in one of three ways. char_avail drops early or stays high after draining. A full queue fails to flag overrun on the next write. Or characters come back out of order within a few reads. A misplaced flag shows as a wrong stat_frm or stat_par in the cycle after the affected entry becomes the oldest. A held latch that is not set, or not cleared, shows on stat_par, stat_ovr or sc_irq in the cycle after the read or the error reset. The directed scenarios drain the queue after every stimulus, so each fault surfaces within a handful of cycles.

// File: rtl/rxq_pkg.sv
package rxq_pkg;
    typedef struct packed {
        logic par;
        logic frm;
        logic ovr;
    } rxq_flags_t;

    typedef enum logic [1:0] {
        ST_EMPTY   = 2'd0,
        ST_PARTIAL = 2'd1,
        ST_FULL    = 2'd2
    } rxq_state_t;
endpackage

// File: rtl/rxq_store.sv
module rxq_store
    import rxq_pkg::*;
#(
    parameter int DW    = 8,
    parameter int DEPTH = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic          pop,
    input  logic          replace,
    input  logic [DW-1:0] in_data,
    input  rxq_flags_t    in_flags,
    output logic [DW-1:0] head_data,
    output rxq_flags_t    head_flags
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [DW-1:0] data_q [DEPTH];
    rxq_flags_t    flag_q [DEPTH];
    logic [PW-1:0] rd_ptr, wr_ptr, last_ptr;

    function automatic logic [PW-1:0] ptr_inc(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_comb begin
        last_ptr = (wr_ptr == '0) ? PW'(DEPTH - 1) : wr_ptr - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_ptr <= '0;
            wr_ptr <= '0;
            for (int i = 0; i < DEPTH; i++) begin
                data_q[i] <= '0;
                flag_q[i] <= '0;
            end
        end else begin
            if (push) begin
                data_q[wr_ptr] <= in_data;
                flag_q[wr_ptr] <= in_flags;
                wr_ptr         <= ptr_inc(wr_ptr);
            end else if (replace) begin
                data_q[last_ptr] <= in_data;
                flag_q[last_ptr] <= '{par: in_flags.par, frm: in_flags.frm, ovr: 1'b1};
            end
            if (pop) begin
                rd_ptr <= ptr_inc(rd_ptr);
            end
        end
    end

    assign head_data  = data_q[rd_ptr];
    assign head_flags = flag_q[rd_ptr];
endmodule

// File: rtl/rxq_status.sv
module rxq_status
    import rxq_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       avail,
    input  logic       pop,
    input  logic       ovr_evt,
    input  logic       err_rst,
    input  logic       irq_en,
    input  rxq_flags_t head_flags,
    output logic       stat_par,
    output logic       stat_frm,
    output logic       stat_ovr,
    output logic       sc_irq
);
    logic par_hold, ovr_hold;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            par_hold <= 1'b0;
            ovr_hold <= 1'b0;
        end else if (err_rst) begin
            par_hold <= 1'b0;
            ovr_hold <= 1'b0;
        end else begin
            if (pop && head_flags.par) par_hold <= 1'b1;
            if (ovr_evt || (pop && head_flags.ovr)) ovr_hold <= 1'b1;
        end
    end

    always_comb begin
        stat_par = par_hold | (avail & head_flags.par);
        stat_frm = avail & head_flags.frm;
        stat_ovr = ovr_hold | (avail & head_flags.ovr);
        sc_irq   = irq_en & stat_par;
    end
endmodule

// File: rtl/rxq_top.sv
module rxq_top
    import rxq_pkg::*;
#(
    parameter int DW    = 8,
    parameter int DEPTH = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [DW-1:0] wr_data,
    input  logic          wr_par_err,
    input  logic          wr_frm_err,
    input  logic          rd_en,
    input  logic          err_rst,
    input  logic          par_irq_en,
    output logic [DW-1:0] rd_data,
    output logic          char_avail,
    output logic          stat_par,
    output logic          stat_frm,
    output logic          stat_ovr,
    output logic          sc_irq
);
    localparam int CW = $clog2(DEPTH + 1);

    rxq_state_t    state, state_nx;
    logic [CW-1:0] cnt, cnt_nx;
    logic          do_push, do_pop, do_ovr;
    logic [DW-1:0] head_data;
    rxq_flags_t    head_flags;
    rxq_flags_t    in_flags;

    assign in_flags = '{par: wr_par_err, frm: wr_frm_err, ovr: 1'b0};

    // transitions and actions per occupancy state
    always_comb begin
        do_push  = 1'b0;
        do_pop   = 1'b0;
        do_ovr   = 1'b0;
        cnt_nx   = cnt;
        state_nx = state;
        unique case (state)
            ST_EMPTY: begin
                do_push = wr_en;
                if (wr_en) begin
                    cnt_nx   = CW'(1);
                    state_nx = (DEPTH == 1) ? ST_FULL : ST_PARTIAL;
                end
            end
            ST_PARTIAL: begin
                do_push = wr_en;
                do_pop  = rd_en;
                if (wr_en && !rd_en) begin
                    cnt_nx   = cnt + 1'b1;
                    state_nx = (cnt_nx == CW'(DEPTH)) ? ST_FULL : ST_PARTIAL;
                end else if (rd_en && !wr_en) begin
                    cnt_nx   = cnt - 1'b1;
                    state_nx = (cnt_nx == '0) ? ST_EMPTY : ST_PARTIAL;
                end
            end
            ST_FULL: begin
                do_pop  = rd_en;
                do_push = wr_en && rd_en;
                do_ovr  = wr_en && !rd_en;
                if (rd_en && !wr_en) begin
                    cnt_nx   = cnt - 1'b1;
                    state_nx = (cnt_nx == '0) ? ST_EMPTY : ST_PARTIAL;
                end
            end
            default: begin
                cnt_nx   = '0;
                state_nx = ST_EMPTY;
            end
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_EMPTY;
            cnt   <= '0;
        end else begin
            state <= state_nx;
            cnt   <= cnt_nx;
        end
    end

    // registered read data
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_data <= '0;
        end else if (do_pop) begin
            rd_data <= head_data;
        end
    end

    assign char_avail = (state != ST_EMPTY);

    rxq_store #(.DW(DW), .DEPTH(DEPTH)) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (do_push),
        .pop       (do_pop),
        .replace   (do_ovr),
        .in_data   (wr_data),
        .in_flags  (in_flags),
        .head_data (head_data),
        .head_flags(head_flags)
    );

    rxq_status u_status (
        .clk       (clk),
        .rst_n     (rst_n),
        .avail     (char_avail),
        .pop       (do_pop),
        .ovr_evt   (do_ovr),
        .err_rst   (err_rst),
        .irq_en    (par_irq_en),
        .head_flags(head_flags),
        .stat_par  (stat_par),
        .stat_frm  (stat_frm),
        .stat_ovr  (stat_ovr),
        .sc_irq    (sc_irq)
    );
endmodule

// File: rtl/rxq_chk.sv
module rxq_chk #(
    parameter int DW    = 8,
    parameter int DEPTH = 3,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input logic          clk,
    input logic          rst_n,
    input logic          wr_en,
    input logic          rd_en,
    input logic          err_rst,
    input logic          par_irq_en,
    input logic [DW-1:0] rd_data,
    input logic          char_avail,
    input logic          stat_par,
    input logic          stat_frm,
    input logic          stat_ovr,
    input logic          sc_irq,
    input logic [CW-1:0] cnt
);
    AST_AVAIL_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
        char_avail == (cnt != '0));  // R2
    AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= CW'(DEPTH));  // R2
    AST_EMPTY_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (!char_avail && rd_en) |=> $stable(rd_data));  // R4
    AST_FRM_HEAD: assert property (@(posedge clk) disable iff (!rst_n)
        stat_frm |-> char_avail);  // R5
    AST_OVR_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt == CW'(DEPTH) && wr_en && !rd_en && !err_rst) |=> stat_ovr);  // R7
    AST_OVR_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_ovr && !err_rst) |=> stat_ovr);  // R7
    AST_PAR_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_par && !err_rst) |=> stat_par);  // R6
    AST_CLEAR_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (err_rst && !wr_en && cnt == '0) |=> (!stat_par && !stat_ovr && !sc_irq));  // R8
    AST_RESET_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
        (err_rst && !rd_en && !wr_en) |=> (cnt == $past(cnt)));  // R8
    AST_IRQ_GATE: assert property (@(posedge clk) disable iff (!rst_n)
        sc_irq |-> (par_irq_en && stat_par));  // R9
    AST_BOTH_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt == CW'(DEPTH) && wr_en && rd_en) |=> (cnt == CW'(DEPTH)));  // R10
endmodule

bind rxq_top rxq_chk #(.DW(DW), .DEPTH(DEPTH)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .rd_en     (rd_en),
    .err_rst   (err_rst),
    .par_irq_en(par_irq_en),
    .rd_data   (rd_data),
    .char_avail(char_avail),
    .stat_par  (stat_par),
    .stat_frm  (stat_frm),
    .stat_ovr  (stat_ovr),
    .sc_irq    (sc_irq),
    .cnt       (cnt)
);

// File: tb/sim_rxq_top.sv
`timescale 1ns/1ps
module sim_rxq_top;
    localparam int CLK_PERIOD = 10;
    localparam int DW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_en = 1'b0;
    logic [DW-1:0] wr_data = '0;
    logic          wr_par_err = 1'b0;
    logic          wr_frm_err = 1'b0;
    logic          rd_en = 1'b0;
    logic          err_rst = 1'b0;
    logic          par_irq_en = 1'b0;
    logic [DW-1:0] rd_data;
    logic          char_avail, stat_par, stat_frm, stat_ovr, sc_irq;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    rxq_top #(.DW(DW), .DEPTH(3)) u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .wr_par_err(wr_par_err), .wr_frm_err(wr_frm_err), .rd_en(rd_en),
        .err_rst(err_rst), .par_irq_en(par_irq_en), .rd_data(rd_data),
        .char_avail(char_avail), .stat_par(stat_par), .stat_frm(stat_frm),
        .stat_ovr(stat_ovr), .sc_irq(sc_irq)
    );

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic put(input logic [DW-1:0] d, input logic p, input logic f);
        wr_en = 1'b1; wr_data = d; wr_par_err = p; wr_frm_err = f;
        tick();
        wr_en = 1'b0; wr_par_err = 1'b0; wr_frm_err = 1'b0;
    endtask

    task automatic get();
        rd_en = 1'b1;
        tick();
        rd_en = 1'b0;
    endtask

    task automatic clear_errors();
        err_rst = 1'b1;
        tick();
        err_rst = 1'b0;
    endtask

    task automatic t_reset();
        chk("R1 avail", char_avail, 0);
        chk("R1 par", stat_par, 0);
        chk("R1 frm", stat_frm, 0);
        chk("R1 ovr", stat_ovr, 0);
        chk("R1 irq", sc_irq, 0);
        chk("R1 data", rd_data, 0);
    endtask

    task automatic t_order();
        put(8'hA1, 0, 0); chk("R2 avail after one", char_avail, 1);
        put(8'hB2, 0, 0);
        put(8'hC3, 0, 0);
        get(); chk("R3 first", rd_data, 8'hA1);
        get(); chk("R3 second", rd_data, 8'hB2);
        chk("R2 avail one left", char_avail, 1);
        get(); chk("R3 third", rd_data, 8'hC3);
        chk("R2 avail drained", char_avail, 0);
    endtask

    task automatic t_empty_read();
        get();
        chk("R4 data kept", rd_data, 8'hC3);
        chk("R4 still empty", char_avail, 0);
        put(8'h44, 0, 0);
        get(); chk("R4 no pointer move", rd_data, 8'h44);
    endtask

    task automatic t_framing();
        put(8'h51, 0, 1);
        put(8'h52, 0, 0);
        chk("R5 frm head", stat_frm, 1);
        get(); chk("R5 frm cleared", stat_frm, 0);
        chk("R5 frm not par", stat_par, 0);
        get(); chk("R5 data", rd_data, 8'h52);
    endtask

    task automatic t_parity();
        par_irq_en = 1'b1;
        put(8'h61, 1, 0);
        chk("R6 par head", stat_par, 1);
        chk("R9 irq armed", sc_irq, 1);
        get();
        chk("R6 par held", stat_par, 1);
        chk("R9 irq held", sc_irq, 1);
        clear_errors();
        chk("R8 par cleared", stat_par, 0);
        chk("R8 irq cleared", sc_irq, 0);
        par_irq_en = 1'b0;
        put(8'h62, 1, 0);
        chk("R6 par again", stat_par, 1);
        chk("R9 irq disarmed", sc_irq, 0);
        get(); clear_errors();
        chk("R8 par cleared 2", stat_par, 0);
    endtask

    task automatic t_overrun();
        put(8'h01, 0, 0); put(8'h02, 0, 0); put(8'h03, 0, 0);
        chk("R7 no ovr yet", stat_ovr, 0);
        put(8'h04, 0, 0);
        chk("R7 ovr set", stat_ovr, 1);
        get(); chk("R7 first kept", rd_data, 8'h01);
        get(); chk("R7 second kept", rd_data, 8'h02);
        get(); chk("R7 newest replaced", rd_data, 8'h04);
        chk("R7 drained", char_avail, 0);
        chk("R7 ovr held", stat_ovr, 1);
        clear_errors();
        chk("R8 ovr cleared", stat_ovr, 0);
    endtask

    task automatic t_reset_keeps_data();
        put(8'h30, 0, 0); put(8'h31, 0, 0);
        clear_errors();
        chk("R8 avail kept", char_avail, 1);
        get(); chk("R8 data kept 1", rd_data, 8'h30);
        get(); chk("R8 data kept 2", rd_data, 8'h31);
    endtask

    task automatic t_both_full();
        put(8'h10, 0, 0); put(8'h11, 0, 0); put(8'h12, 0, 0);
        wr_en = 1'b1; rd_en = 1'b1; wr_data = 8'h13;
        tick();
        wr_en = 1'b0; rd_en = 1'b0;
        chk("R10 read when full", rd_data, 8'h10);
        chk("R10 no overrun", stat_ovr, 0);
        get(); chk("R10 order 1", rd_data, 8'h11);
        get(); chk("R10 order 2", rd_data, 8'h12);
        get(); chk("R10 write taken", rd_data, 8'h13);
        chk("R10 drained", char_avail, 0);
    endtask

    task automatic t_both_empty();
        wr_en = 1'b1; rd_en = 1'b1; wr_data = 8'h20;
        tick();
        wr_en = 1'b0; rd_en = 1'b0;
        chk("R10 empty read ignored", rd_data, 8'h13);
        chk("R10 write kept", char_avail, 1);
        get(); chk("R10 new data", rd_data, 8'h20);
    endtask

    initial begin
        tick(); tick();
        rst_n = 1'b1;
        tick();
        t_reset();
        t_order();
        t_empty_read();
        t_framing();
        t_parity();
        t_overrun();
        t_reset_keeps_data();
        t_both_full();
        t_both_empty();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        for (int i = 0; i < 5000; i++) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule